// File: doc/BRIEF.md
# Load/Store Byte-Lane Data Unit

This unit sits between a 32-bit register file and a data memory that is one word wide. Each cycle it can accept one memory request. It forms the effective address by adding a sign-extended immediate offset to a base register value. It then drives a word-aligned address to the memory.

For stores, it moves the low bits of the source register onto the byte lanes picked by the address and raises a write strobe for each lane it writes. For loads, it takes the addressed word that the memory returns in the same cycle, selects the byte or halfword, and extends that value to a full register width. The extension is signed or unsigned, as the request asks. The load result comes back one clock later with a valid strobe.

A request whose address does not match its access size raises a misalignment flag in the same cycle. Such a request never reaches the memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base_addr` plus `imm_off` sign-extended to 32 bits, with the sum taken modulo 2^32. For every accepted request, `mem_addr` equals the effective address with bits [1:0] cleared. The access size is coded on `req_size` as 00 byte, 01 halfword, 10 word; 11 behaves as word.
- R2: A signed byte load returns the byte on lane `ea[1:0]`, where lane k is bits [8k+7:8k] of the memory word. Result bits [31:8] are copies of that byte's bit 7.
- R3: An unsigned byte or halfword load (`req_unsigned`=1) returns the selected value with every higher result bit zero.
- R4: A signed halfword load returns bits [31:16] of the memory word when `ea[1]`=1, and bits [15:0] otherwise. Result bits [31:16] are copies of the halfword's bit 15.
- R5: A word load returns the memory word unchanged.
- R6: `ld_valid` is high in the cycle after a load is accepted and low in every other cycle. `ld_data` holds the result of the most recent accepted load.
- R7: A byte store asserts exactly strobe bit `ea[1:0]`. It places `store_data[7:0]` on that lane and drives zero on every other lane of `mem_wdata`.
- R8: A halfword store asserts strobe 4'b0011 when `ea[1]`=0 and 4'b1100 when `ea[1]`=1. It places `store_data[15:0]` on those lanes and zero elsewhere.
- R9: A word store asserts strobe 4'b1111 and writes `store_data` unchanged.
- R10: A halfword request with `ea[0]`=1, or a word request with `ea[1:0]`≠0, sets `misalign` in the request cycle. Such a request keeps `mem_we`, `mem_re` and `mem_wstrb` low and produces no `ld_valid`.
- R11: During and after reset, with no request present, `ld_valid`, `mem_we`, `mem_re`, `misalign` and `mem_wstrb` are all zero. `mem_wstrb` is zero whenever `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-extend a byte or halfword load |
| base_addr | input | 32 | Base register value |
| imm_off | input | 16 | Signed immediate offset |
| store_data | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word read from `mem_addr` in the same cycle |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_re | output | 1 | Read request to memory |
| mem_we | output | 1 | Write request to memory |
| mem_wstrb | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| misalign | output | 1 | Address does not match access size |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The first stores fill memory words whose lanes contain both small values and values with the top bit set. Byte and halfword loads at every lane offset, in both signed and unsigned forms, then separate a wrong lane choice from a wrong extension. Stores at each offset, read back as whole words, reveal stray lane writes or data that was not zeroed on the unused lanes. Negative offsets and an address sum that wraps past 2^32 test the adder. Misaligned halfword and word addresses check that the write is suppressed and that no load returns. A long run of random mixed requests, issued back to back, checks that results do not slip between consecutive loads.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  // Width of the byte-offset field for a given data width.
  function automatic int unsigned off_bits(input int unsigned data_w);
    return $clog2(data_w / 8);
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              bad_align_o
);

  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;

  always_comb begin
    imm_ext     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    ea_o        = base_i + imm_ext;
    off_o       = ea_o[OFF_W-1:0];
    word_addr_o = {ea_o[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    unique case (size_i)
      SZ_BYTE: bad_align_o = 1'b0;
      SZ_HALF: bad_align_o = ea_o[0];
      default: bad_align_o = |ea_o[OFF_W-1:0];
    endcase
  end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [DATA_W-1:0]   src_i,
  input  acc_size_e           size_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [DATA_W/8-1:0] lane_en_o,
  output logic [DATA_W-1:0]   wdata_o
);

  localparam int unsigned LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned HALF_IDX  = g / 2;
    localparam int unsigned HALF_BYTE = g % 2;

    logic       sel;
    logic [7:0] src_byte;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          sel      = (off_i == OFF_W'(g));
          src_byte = src_i[7:0];
        end
        SZ_HALF: begin
          sel      = (off_i[OFF_W-1:1] == (OFF_W-1)'(HALF_IDX));
          src_byte = src_i[8*HALF_BYTE +: 8];
        end
        default: begin
          sel      = 1'b1;
          src_byte = src_i[8*g +: 8];
        end
      endcase
    end

    assign lane_en_o[g]      = sel;
    assign wdata_o[8*g +: 8] = sel ? src_byte : 8'h00;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  acc_size_e         size_i,
  input  logic              uns_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] value_o
);

  localparam int unsigned HALVES = DATA_W / 16;

  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic [15:0] half_arr [HALVES];

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign half_arr[g] = word_i[16*g +: 16];
  end

  always_comb begin
    byte_v = word_i[8*off_i +: 8];
    half_v = half_arr[off_i[OFF_W-1:1]];
    unique case (size_i)
      SZ_BYTE: value_o = {{(DATA_W-8){byte_v[7] & ~uns_i}}, byte_v};
      SZ_HALF: value_o = {{(DATA_W-16){half_v[15] & ~uns_i}}, half_v};
      default: value_o = word_i;
    endcase
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [IMM_W-1:0]    imm_off,
  input  logic [DATA_W-1:0]   store_data,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_re,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_wstrb,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                misalign,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = off_bits(DATA_W);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Address generation
  acc_size_e          size_e;
  logic [ADDR_W-1:0]  ea;
  logic [ADDR_W-1:0]  word_addr;
  logic [OFF_W-1:0]   off;
  logic               bad_align;

  assign size_e = acc_size_e'(req_size);

  lsu_agen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .OFF_W  (OFF_W)
  ) u_agen (
    .base_i      (base_addr),
    .imm_i       (imm_off),
    .size_i      (size_e),
    .ea_o        (ea),
    .word_addr_o (word_addr),
    .off_o       (off),
    .bad_align_o (bad_align)
  );

  // Request qualification
  logic go;
  logic store_go;
  logic load_go;

  assign misalign = req_valid & bad_align;
  assign go       = req_valid & ~bad_align;
  assign store_go = go & req_store;
  assign load_go  = go & ~req_store;

  // Store lane steering
  logic [LANES-1:0] lane_en;

  lsu_store_steer #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) u_steer (
    .src_i     (store_data),
    .size_i    (size_e),
    .off_i     (off),
    .lane_en_o (lane_en),
    .wdata_o   (mem_wdata)
  );

  assign mem_addr  = word_addr;
  assign mem_we    = store_go;
  assign mem_re    = load_go;
  assign mem_wstrb = lane_en & {LANES{store_go}};

  // Load extraction
  logic [DATA_W-1:0] ld_value;

  lsu_load_extract #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) u_extract (
    .word_i  (mem_rdata),
    .size_i  (size_e),
    .uns_i   (req_unsigned),
    .off_i   (off),
    .value_o (ld_value)
  );

  // Load result register: next state, then storage
  logic              ld_valid_d;
  logic              ld_data_en;
  logic [DATA_W-1:0] ld_data_d;

  always_comb begin
    ld_valid_d = load_go;
    ld_data_en = load_go;
    ld_data_d  = ld_value;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ld_valid <= 1'b0;
    end else begin
      ld_valid <= ld_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ld_data <= '0;
    end else if (ld_data_en) begin
      ld_data <= ld_data_d;
    end
  end

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                req_valid,
  input logic                req_store,
  input logic [1:0]          req_size,
  input logic                req_unsigned,
  input logic                misalign,
  input logic                mem_re,
  input logic                mem_we,
  input logic [DATA_W/8-1:0] mem_wstrb,
  input logic                ld_valid,
  input logic [DATA_W-1:0]   ld_data
);

  localparam int unsigned LANES = DATA_W / 8;

  // R10
  misalign_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    misalign |-> (!mem_we && !mem_re && (mem_wstrb == '0)));

  // R7
  byte_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_we && req_size == 2'b00) |-> ($countones(mem_wstrb) == 1));

  // R8
  half_strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_we && req_size == 2'b01) |-> (mem_wstrb == 4'b0011 || mem_wstrb == 4'b1100));

  // R9
  word_strobe_full_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_we && req_size[1]) |-> (mem_wstrb == {LANES{1'b1}}));

  // R11
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_we |-> (mem_wstrb == '0));

  // R6
  load_return_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !req_store && !misalign) |=> ld_valid);

  // R6
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_valid |-> $past(req_valid && !req_store && !misalign));

  // R2
  byte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_valid && $past(req_size == 2'b00 && !req_unsigned))
      |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));

  // R4
  half_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_valid && $past(req_size == 2'b01 && !req_unsigned))
      |-> (ld_data[DATA_W-1:16] == {(DATA_W-16){ld_data[15]}}));

  // R3
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_valid && $past(req_size == 2'b00 && req_unsigned))
      |-> (ld_data[DATA_W-1:8] == '0));

  // R3
  half_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_valid && $past(req_size == 2'b01 && req_unsigned))
      |-> (ld_data[DATA_W-1:16] == '0));

endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .req_valid    (req_valid),
  .req_store    (req_store),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .misalign     (misalign),
  .mem_re       (mem_re),
  .mem_we       (mem_we),
  .mem_wstrb    (mem_wstrb),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data)
);

// File: tb/lsu_lane_unit_bench.sv
module lsu_lane_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_store;
  logic [1:0]  req_size;
  logic        req_unsigned;
  logic [31:0] base_addr;
  logic [15:0] imm_off;
  logic [31:0] store_data;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic        mem_re;
  logic        mem_we;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic        ld_valid;
  logic [31:0] ld_data;

  lsu_lane_unit u_lsu_lane_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .base_addr    (base_addr),
    .imm_off      (imm_off),
    .store_data   (store_data),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_re       (mem_re),
    .mem_we       (mem_we),
    .mem_wstrb    (mem_wstrb),
    .mem_wdata    (mem_wdata),
    .misalign     (misalign),
    .ld_valid     (ld_valid),
    .ld_data      (ld_data)
  );

  // Bench-owned memory: 16 words, indexed by address bits [5:2]
  logic [31:0] mem [16];
  assign mem_rdata = mem[mem_addr[5:2]];

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit in_reset;

  logic        pend_v;
  logic [31:0] pend_d;
  string       pend_tag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model, evaluated away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] ea, w, v, exp_wd;
      logic [3:0]  exp_st;
      logic        bad, ok;
      int          off;

      if (in_reset) begin
        check(ld_valid == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0 &&
              misalign == 1'b0 && mem_wstrb == 4'b0, "R11", "idle during reset",
              {ld_valid, mem_we, mem_re, misalign, mem_wstrb}, 32'h0);
        pend_v = 1'b0;
      end else begin
        // R6: load return from the previous cycle
        check(ld_valid == pend_v, "R6", "ld_valid", {31'b0, ld_valid}, {31'b0, pend_v});
        if (pend_v)
          check(ld_data == pend_d, pend_tag, "ld_data", ld_data, pend_d);

        ea  = base_addr + {{16{imm_off[15]}}, imm_off};
        off = int'(ea[1:0]);
        unique case (req_size)
          2'b00:   bad = 1'b0;
          2'b01:   bad = ea[0];
          default: bad = (ea[1:0] != 2'b00);
        endcase
        ok = req_valid && !bad;

        check(misalign == (req_valid && bad), "R10", "misalign",
              {31'b0, misalign}, {31'b0, req_valid && bad});
        check(mem_we == (ok && req_store), "R10", "mem_we",
              {31'b0, mem_we}, {31'b0, ok && req_store});
        check(mem_re == (ok && !req_store), "R10", "mem_re",
              {31'b0, mem_re}, {31'b0, ok && !req_store});
        if (!(ok && req_store))
          check(mem_wstrb == 4'b0, "R11", "strobe idle", {28'b0, mem_wstrb}, 32'h0);
        if (ok)
          check(mem_addr == {ea[31:2], 2'b00}, "R1", "mem_addr", mem_addr, {ea[31:2], 2'b00});

        pend_v = 1'b0;
        if (ok && !req_store) begin
          w = mem[ea[5:2]];
          if (req_size == 2'b00) begin
            v = (w >> (8*off)) & 32'hFF;
            if (!req_unsigned && v[7]) v = v | 32'hFFFF_FF00;
            pend_tag = req_unsigned ? "R3" : "R2";
          end else if (req_size == 2'b01) begin
            v = (w >> (16*(off/2))) & 32'hFFFF;
            if (!req_unsigned && v[15]) v = v | 32'hFFFF_0000;
            pend_tag = req_unsigned ? "R3" : "R4";
          end else begin
            v = w;
            pend_tag = "R5";
          end
          pend_v = 1'b1;
          pend_d = v;
        end

        if (ok && req_store) begin
          string stag;
          exp_wd = 32'h0;
          if (req_size == 2'b00) begin
            exp_st = 4'b0001 << off;
            exp_wd = {24'h0, store_data[7:0]} << (8*off);
            stag   = "R7";
          end else if (req_size == 2'b01) begin
            exp_st = (off >= 2) ? 4'b1100 : 4'b0011;
            exp_wd = {16'h0, store_data[15:0]} << (16*(off/2));
            stag   = "R8";
          end else begin
            exp_st = 4'b1111;
            exp_wd = store_data;
            stag   = "R9";
          end
          check(mem_wstrb == exp_st, stag, "mem_wstrb", {28'b0, mem_wstrb}, {28'b0, exp_st});
          check(mem_wdata == exp_wd, stag, "mem_wdata", mem_wdata, exp_wd);
          for (int b = 0; b < 4; b++)
            if (exp_st[b]) mem[ea[5:2]][8*b +: 8] = exp_wd[8*b +: 8];
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic issue(input bit st, input logic [1:0] sz, input bit uns,
                       input logic [31:0] base, input logic [15:0] imm,
                       input logic [31:0] sd);
    @(posedge clk); #1;
    req_valid    = 1'b1;
    req_store    = st;
    req_size     = sz;
    req_unsigned = uns;
    base_addr    = base;
    imm_off      = imm;
    store_data   = sd;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    pend_v       = 1'b0;
    pend_d       = 32'h0;
    pend_tag     = "R6";
    in_reset     = 1'b1;
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_store    = 1'b0;
    req_size     = 2'b00;
    req_unsigned = 1'b0;
    base_addr    = 32'h0;
    imm_off      = 16'h0;
    store_data   = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 in_reset = 1'b0;
    repeat (2) idle();

    // Word stores with mixed sign bits in each lane (R9)
    issue(1, 2'b10, 0, 32'h0000_0000, 16'h0000, 32'h80FF_7F01);
    issue(1, 2'b10, 0, 32'h0000_0010, 16'hFFF4, 32'h1234_ABCD);
    // Word load back (R5)
    issue(0, 2'b10, 0, 32'h0000_0000, 16'h0000, 32'h0);
    // Byte loads, every lane, signed and unsigned (R2, R3)
    for (int k = 0; k < 4; k++) begin
      issue(0, 2'b00, 0, 32'h0, 16'(k), 32'h0);
      issue(0, 2'b00, 1, 32'h0, 16'(k), 32'h0);
    end
    // Halfword loads, both halves (R4, R3)
    issue(0, 2'b01, 0, 32'h4, 16'h0000, 32'h0);
    issue(0, 2'b01, 0, 32'h4, 16'h0002, 32'h0);
    issue(0, 2'b01, 1, 32'h4, 16'h0002, 32'h0);
    issue(0, 2'b01, 0, 32'h0, 16'h0000, 32'h0);
    issue(0, 2'b01, 0, 32'h0, 16'h0002, 32'h0);
    // Byte stores at every lane, word read-back (R7)
    for (int k = 0; k < 4; k++)
      issue(1, 2'b00, 0, 32'h20, 16'(k), 32'hDEAD_BE00 | 32'(k + 8'hA0));
    issue(0, 2'b10, 0, 32'h20, 16'h0, 32'h0);
    // Halfword stores, both halves (R8)
    issue(1, 2'b01, 0, 32'h30, 16'h0, 32'hFFFF_8001);
    issue(1, 2'b01, 0, 32'h30, 16'h2, 32'h0000_7FFE);
    issue(0, 2'b10, 0, 32'h30, 16'h0, 32'h0);
    // Negative offset and wrapping sum (R1)
    issue(0, 2'b10, 0, 32'h0000_0008, 16'hFFFC, 32'h0);
    issue(0, 2'b10, 0, 32'hFFFF_FFF0, 16'h0014, 32'h0);
    // Misaligned requests (R10)
    issue(1, 2'b01, 0, 32'h30, 16'h1, 32'h5555_5555);
    issue(1, 2'b10, 0, 32'h30, 16'h2, 32'h5555_5555);
    issue(0, 2'b10, 0, 32'h30, 16'h3, 32'h0);
    issue(0, 2'b01, 1, 32'h30, 16'h3, 32'h0);
    issue(0, 2'b10, 0, 32'h30, 16'h0, 32'h0);
    issue(1, 2'b11, 0, 32'h31, 16'h0, 32'h5555_5555);
    issue(0, 2'b11, 0, 32'h34, 16'h0, 32'h0);
    idle();
    // Random back-to-back traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] rb;
      logic [15:0] ri;
      rb = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h3F);
      ri = 16'($signed($urandom % 64) - 32);
      if ($urandom % 8 == 0) idle();
      else issue($urandom % 2, 2'($urandom), $urandom % 2, rb, ri, $urandom);
    end
    repeat (3) idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule